// File: doc/BRIEF.md
# Asynchronous Static Memory Bus Controller

This controller takes single read or write requests from a synchronous host and runs each one as an asynchronous cycle on an external static memory: SRAM, PSRAM or NOR flash. Every phase of a memory cycle lasts a fixed whole number of host clock cycles. The memory pins are all registered, so each strobe edge lines up with a host clock edge.

The controller has two bus modes, chosen per request by `mux_mode`. In the split mode, the address sits on its own bus and the 16-bit data bus carries only data. In the shared mode, the low address bits go out first on the data bus under an address-latch strobe, and then the same bus carries the write data or is released for the read data. The host offers a request for one cycle while the controller is idle. The controller replies with a one-cycle `ready` pulse, and for a read `rdata` holds the word in that cycle.

Top module: `xmem_async_bridge`

## Requirements
- R1: After reset, and whenever no access is running, `mem_ce_n`, `mem_oe_n`, `mem_we_n` and `mem_adv_n` are 1, `mem_bl_n` is all ones, `ad_oe` is 0 and `ready` is 0.
- R2: Split-mode read (`mux_mode`=0, `wr`=0): `mem_ce_n` is low for 2 cycles, `mem_oe_n` is low for those same 2 cycles, and the data bus is not driven.
- R3: Split-mode write: `mem_ce_n` is low for 3 cycles. `mem_we_n` is low only in the 2nd of them, which leaves one hold cycle before chip enable rises. `ad_out` carries `wdata` with `ad_oe`=1 for all 3 cycles.
- R4: Shared-mode read: `mem_ce_n` is low for 3 cycles. `mem_adv_n` is low in cycle 1. `ad_out` carries `addr[15:0]` in cycles 1 and 2. In cycle 3 the bus is released and `mem_oe_n` is low.
- R5: Shared-mode write: `mem_ce_n` is low for 4 cycles. `mem_adv_n` is low in cycle 1 and `mem_we_n` is low in cycles 2 and 3. `ad_out` carries `addr[15:0]` in cycles 1 and 2 and `wdata` in cycles 3 and 4.
- R6: In split mode, `mem_adv_n` is low in the first chip-enable cycle when the parameter `NM_ADV_PULSE` is 1. When it is 0, `mem_adv_n` stays high.
- R7: While `mem_ce_n` is low, `mem_bl_n` equals `~be` and `mem_addr` equals `addr`, both taken from the accepted request.
- R8: A request sampled at clock edge k drives `mem_ce_n` low from edge k. `ready` is high for exactly one cycle, in the cycle right after the last chip-enable cycle. For a read, `rdata` in that cycle equals the `ad_in` value present in the last cycle with `mem_oe_n` low.
- R9: `req` is accepted only when no access is in progress. A `req` during an access has no effect on the pins or on `ready`. A `req` in the `ready` cycle is accepted, so only one idle cycle separates the two accesses.
- R10: `mem_oe_n` and `mem_we_n` are never low together, and `ad_oe` is 0 whenever `mem_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle access request |
| wr | input | 1 | 1 = write, 0 = read |
| mux_mode | input | 1 | 1 = shared address/data bus, 0 = split buses |
| addr | input | AW | Access address |
| wdata | input | DW | Write data |
| be | input | DW/8 | Byte lanes to enable, active high |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Read data, valid with `ready` on reads |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_bl_n | output | DW/8 | Byte-lane selects, active low |
| mem_addr | output | AW | Address bus |
| ad_out | output | DW | Value driven on the shared data bus |
| ad_oe | output | 1 | Drive enable for the shared data bus |
| ad_in | input | DW | Value sampled from the shared data bus |

## Verification
The bench builds the controller with AW=20, DW=16 and `NM_ADV_PULSE`=1. With these values the bench exercises the split-mode address strobe and both bus modes, and the data bus is wide enough for the two byte lanes to be set one at a time or together. The bench memory returns a marker value whenever output enable is high, so a read that samples one cycle too early or too late gives a visibly wrong word. Directed sequences cover back-to-back accesses and requests made during an access. After them comes a long pseudo-random run that mixes the mode, the direction and the idle gaps.

// File: rtl/xmem_async_bridge.sv
module xmem_async_bridge #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter bit NM_ADV_PULSE = 1'b1,
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic          mux_mode,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [BW-1:0] be,
  output logic          ready,
  output logic [DW-1:0] rdata,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_adv_n,
  output logic [BW-1:0] mem_bl_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in
);

  logic          busy, op_wr, op_mux;
  logic [1:0]    ph, last;
  logic [DW-1:0] op_wdata;
  logic [BW-1:0] op_be;

  wire accept = req && !busy;
  assign last = op_mux ? (op_wr ? 2'd3 : 2'd2) : (op_wr ? 2'd2 : 2'd1);
  wire done   = busy && (ph == last);

  wire          n_busy  = accept || (busy && !done);
  wire [1:0]    n_ph    = accept ? 2'd0 : ph + 2'd1;
  wire          n_wr    = accept ? wr : op_wr;
  wire          n_mux   = accept ? mux_mode : op_mux;
  wire [AW-1:0] n_addr  = accept ? addr : mem_addr;
  wire [DW-1:0] n_wdata = accept ? wdata : op_wdata;
  wire [BW-1:0] n_be    = accept ? be : op_be;

  wire s_oe   = n_busy && !n_wr && (n_mux ? (n_ph == 2'd2) : 1'b1);
  wire s_we   = n_busy && n_wr && (n_mux ? (n_ph == 2'd1 || n_ph == 2'd2) : (n_ph == 2'd1));
  wire s_adv  = n_busy && (n_ph == 2'd0) && (n_mux || NM_ADV_PULSE);
  wire s_adph = n_mux && (n_ph < 2'd2);
  wire s_drv  = n_busy && (s_adph || n_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      ph        <= 2'd0;
      op_wr     <= 1'b0;
      op_mux    <= 1'b0;
      op_wdata  <= '0;
      op_be     <= '0;
      mem_addr  <= '0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_adv_n <= 1'b1;
      mem_bl_n  <= '1;
      ad_out    <= '0;
      ad_oe     <= 1'b0;
      ready     <= 1'b0;
      rdata     <= '0;
    end else begin
      busy      <= n_busy;
      ph        <= n_ph;
      op_wr     <= n_wr;
      op_mux    <= n_mux;
      op_wdata  <= n_wdata;
      op_be     <= n_be;
      mem_addr  <= n_addr;
      mem_ce_n  <= !n_busy;
      mem_oe_n  <= !s_oe;
      mem_we_n  <= !s_we;
      mem_adv_n <= !s_adv;
      mem_bl_n  <= n_busy ? ~n_be : '1;
      ad_out    <= s_adph ? n_addr[DW-1:0] : n_wdata;
      ad_oe     <= s_drv;
      ready     <= done;
      if (done && !op_wr) rdata <= ad_in;
    end
  end

  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_oe_n && mem_we_n && mem_adv_n && !ad_oe && mem_bl_n == '1));

  // R10
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  // R10
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !ad_oe);

  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  // R8
  ready_after_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> ready);

  // R9
  start_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> $past(req));

  // R3
  we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_ce_n);

endmodule

// File: tb/xmem_async_bridge_bench.sv
module xmem_async_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam bit NM_ADV = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0, mux_mode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [1:0] be = '0;
  logic ready;
  logic [DW-1:0] rdata, ad_out, ad_in;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_adv_n, ad_oe;
  logic [1:0] mem_bl_n;
  logic [AW-1:0] mem_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench memory: pattern while output enable is low, marker otherwise
  assign ad_in = mem_oe_n ? 16'hDEAD : (mem_addr[15:0] ^ 16'h5A3C);

  xmem_async_bridge #(.AW(AW), .DW(DW), .NM_ADV_PULSE(NM_ADV)) u_xmem_async_bridge (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .mux_mode(mux_mode),
    .addr(addr), .wdata(wdata), .be(be), .ready(ready), .rdata(rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_adv_n(mem_adv_n), .mem_bl_n(mem_bl_n), .mem_addr(mem_addr),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in));

  typedef struct {
    logic ce, oe, we, adv;
    logic [1:0] bl;
    logic drv;
    logic [DW-1:0] ad;
    logic chk_addr;
    logic [AW-1:0] a;
    logic rdy;
    logic chk_rd;
    logic [DW-1:0] rd;
    string tag;
  } exp_t;

  exp_t q[$];
  int vectors = 0;
  int errors = 0;
  bit finished = 0;

  function automatic exp_t idle_vec(string tag);
    exp_t e;
    e.ce = 1; e.oe = 1; e.we = 1; e.adv = 1; e.bl = 2'b11; e.drv = 0; e.ad = '0;
    e.chk_addr = 0; e.a = '0; e.rdy = 0; e.chk_rd = 0; e.rd = '0; e.tag = tag;
    return e;
  endfunction

  task automatic compare();
    exp_t e;
    bit bad;
    e = (q.size() != 0) ? q.pop_front() : idle_vec("R1 R9");
    vectors++;
    bad = {mem_ce_n, mem_oe_n, mem_we_n, mem_adv_n, mem_bl_n, ad_oe, ready} !==
          {e.ce, e.oe, e.we, e.adv, e.bl, e.drv, e.rdy};
    if (e.drv && ad_out !== e.ad) bad = 1;
    if (e.chk_addr && mem_addr !== e.a) bad = 1;
    if (e.chk_rd && rdata !== e.rd) bad = 1;
    if (bad) begin
      errors++;
      $display("FAIL %s t=%0t: got ce=%b oe=%b we=%b adv=%b bl=%b oe_bus=%b ad=%h addr=%h rdy=%b rd=%h | exp ce=%b oe=%b we=%b adv=%b bl=%b oe_bus=%b ad=%h addr=%h rdy=%b rd=%h",
        e.tag, $time, mem_ce_n, mem_oe_n, mem_we_n, mem_adv_n, mem_bl_n, ad_oe, ad_out, mem_addr, ready, rdata,
        e.ce, e.oe, e.we, e.adv, e.bl, e.drv, e.ad, e.a, e.rdy, e.rd);
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    req = 1'b0;
  endtask

  // Expected pin sequence of one access, one entry per cycle after acceptance
  task automatic push_access(bit m, bit w, logic [AW-1:0] a, logic [DW-1:0] d, logic [1:0] b);
    int len = m ? (w ? 4 : 3) : (w ? 3 : 2);
    for (int i = 0; i < len; i++) begin
      exp_t e = idle_vec("");
      e.tag = m ? (w ? "R5 R7 R10" : "R4 R7 R10") : (w ? "R3 R6 R7 R10" : "R2 R6 R7 R10");
      e.ce  = 0;
      e.oe  = !(!w && (m ? (i == 2) : 1'b1));
      e.we  = !(w && (m ? (i == 1 || i == 2) : (i == 1)));
      e.adv = !(i == 0 && (m || NM_ADV));
      e.bl  = ~b;
      e.drv = (m && i < 2) || w;
      e.ad  = (m && i < 2) ? a[15:0] : d;
      e.chk_addr = 1; e.a = a;
      q.push_back(e);
    end
    begin
      exp_t r = idle_vec("R8");
      r.rdy = 1;
      r.chk_rd = !w;
      r.rd = a[15:0] ^ 16'h5A3C;
      q.push_back(r);
    end
  endtask

  task automatic issue(bit m, bit w, logic [AW-1:0] a, logic [DW-1:0] d, logic [1:0] b,
                       int gap, bit junk);
    while (q.size() != 0) step();
    req = 1; mux_mode = m; wr = w; addr = a; wdata = d; be = b;
    push_access(m, w, a, d, b);
    step();
    if (junk) begin
      // R9: request during an access must leave the expected sequence untouched
      req = 1; mux_mode = !m; wr = !w; addr = ~a; wdata = ~d; be = ~b;
      step();
    end
    for (int g = 0; g < gap; g++) step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 4; i++) step();
    rst_n = 1;
    for (int i = 0; i < 3; i++) step();

    // R2/R3/R4/R5 with each byte-lane pattern (R7)
    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 2; w++)
        for (int b = 0; b < 4; b++)
          issue(m[0], w[0], 20'h1_2345 + 20'(b * 16'h111), 16'hC0DE ^ 16'(b), b[1:0], 2, 0);

    // R9: back-to-back accesses accepted in the ready cycle
    issue(1, 1, 20'hF_F00F, 16'hBEEF, 2'b11, 0, 0);
    issue(0, 0, 20'h0_0A5A, 16'h0000, 2'b01, 0, 0);
    issue(1, 0, 20'h8_1234, 16'h0000, 2'b10, 0, 0);
    issue(0, 1, 20'h7_FFFF, 16'h1357, 2'b11, 0, 0);

    // R9: requests while busy are ignored
    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 2; w++)
        issue(m[0], w[0], 20'h3_3C3C, 16'hA1B2, 2'b10, 1, 1);

    // mixed pseudo-random run
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r = $urandom();
      issue(r[0], r[1], r[21:2], r[31:16] ^ 16'(n), r[23:22], int'(r[25:24]) % 3, r[26] & r[27]);
    end

    while (q.size() != 0) step();
    for (int i = 0; i < 3; i++) step();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule